// File: doc/BRIEF.md
# Multi-Master Bus Arbiter with Split Masking

This block decides which of several bus masters owns a shared bus. A table of arbitration channels, packed into 32-bit configuration words, is visited round-robin. Each channel names one master that may win a slot. The grant moves only when the current transfer ends, which is signalled by the ready input being high at a clock edge. There is no data path, so no valid/ready stream exists at the edge of the block. Ready acts as the only back-pressure: while it is low, the grant is frozen whatever the requests do.

A slave can answer a transfer with a split response. When that happens, the granted master loses the bus and is masked. The target slave is then held busy, and every request aimed at it is kept out of arbitration. When the slave raises that master's bit in the 16-bit release vector, the mask and the busy state both clear. The freed master then takes the very next arbitration round ahead of every other requester.

While the bus is parked on the default master (master 0) and is idle, a counter runs. If the idle stretch exceeds a programmed limit, a sticky timeout flag is set. A select input routes the flag either to an interrupt output or to a reset-request output.

Top module: `split_bus_arbiter`

## Requirements
- R1: After reset the grant is parked on master 0 (`grant_o` = 0001, `master_o` = 0), and both timeout outputs are low.
- R2: Channel c is the byte at bit offset 32*(c/4) + 8*(3 - c%4) of `chan_cfg_i`, so channel 0 sits in bits 31:24 of the first word. In that byte, bit 7 enables the channel and bits 3:0 name its master. A master number of NUM_MASTERS or more makes the channel unusable. Bits 6:4 do not affect arbitration.
- R3: In an arbitration round, channels are scanned starting one after the last channel that won, wrapping around. The first enabled channel whose master is eligible wins. A master is eligible if it is requesting, is not masked, and its target slave is not busy. If no channel qualifies, the grant parks on master 0 and the last-won channel is unchanged.
- R4: The grant changes only on a clock edge where `ready_i` is high. `grant_o` is always the one-hot form of `master_o`.
- R5: A split response (`split_resp_i` high with `ready_i`) masks the granted master at once, already in that round. Its requests are then ignored until its release bit arrives.
- R6: A split marks the granted master's target slave busy. Requests of any master aimed at a busy slave are ignored. The busy state clears when the release bit of the master that was split arrives.
- R7: A master freed by its release bit wins the first arbitration round after the release, and only that round, provided it is requesting. If several masters are freed, the lowest index wins. A winner of this kind does not move the round-robin position. Release bits of masters that are not masked have no effect.
- R8: The idle count advances on each cycle in which master 0 holds the grant and `bus_idle_i` is high. Any other cycle restarts the count. The flag is set on the edge that ends the (limit+1)-th consecutive such cycle.
- R9: The timeout flag stays set until `tmo_clear_i` is high at a clock edge. That edge clears both the flag and the idle count.
- R10: With `tmo_to_reset_i` low, the flag drives `tmo_irq_o`. With it high, the flag drives `tmo_rst_o` instead. The other output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_MASTERS | Bus request, one bit per master |
| req_slave_i | input | NUM_MASTERS*SLV_W | Target slave index of each master, master m in bits m*SLV_W upward |
| chan_cfg_i | input | 32*NUM_CFG_REGS | Channel table, configuration word r in bits 32r+31:32r |
| ready_i | input | 1 | Current transfer ends at this edge; arbitration takes place |
| split_resp_i | input | 1 | The ending transfer received a split response |
| bus_idle_i | input | 1 | The current bus cycle is an idle transfer |
| split_release_i | input | 16 | Split release, one bit per master index |
| tmo_limit_i | input | TMO_W | Allowed idle cycles on the default master |
| tmo_to_reset_i | input | 1 | Route the timeout to the reset request instead of the interrupt |
| tmo_clear_i | input | 1 | Clear the timeout flag and the idle count |
| grant_o | output | NUM_MASTERS | One-hot bus grant |
| master_o | output | MST_W | Index of the granted master |
| tmo_irq_o | output | 1 | Timeout interrupt |
| tmo_rst_o | output | 1 | Timeout reset request |

## Verification
The assertions assume that a split response is only given to a master that really owns the bus, is not masked, and is not merely parked. They also assume that a release bit never arrives on the same edge as a split of the same master, so that the busy state always belongs to a masked owner. The stimulus respects these assumptions: it splits only a master that won a round with a live request, and it sends release pulses one at a time, on edges without a split. Idle-timeout runs use no requests, so the grant stays parked on master 0 throughout.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int CFG_WORD_W  = 32;
  localparam int CH_PER_WORD = 4;
  localparam int REL_W       = 16;

  typedef struct packed {
    logic       en;
    logic [2:0] spare;
    logic [3:0] mst;
  } chan_cfg_t;
endpackage

// File: rtl/arb_chan_pick.sv
module arb_chan_pick
  import arb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int NM  = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic [NCH*8-1:0] chan_flat_i,
  input  logic [NM-1:0]    elig_i,
  input  logic [CW-1:0]    last_ch_i,
  output logic             found_o,
  output logic [CW-1:0]    pick_ch_o,
  output logic [MW-1:0]    pick_mst_o
);
  chan_cfg_t f;
  int        c;
  logic      unused_spare;

  // Scan channels after the last winner, wrapping; first usable wins.
  always_comb begin
    found_o      = 1'b0;
    pick_ch_o    = '0;
    pick_mst_o   = '0;
    unused_spare = 1'b0;
    f            = '0;
    c            = 0;
    for (int i = 1; i <= NCH; i++) begin
      c = (int'(last_ch_i) + i) % NCH;
      f = chan_cfg_t'(chan_flat_i[c*8 +: 8]);
      unused_spare = unused_spare ^ (^f.spare);
      if (!found_o && f.en && (32'(f.mst) < NM) && elig_i[f.mst[MW-1:0]]) begin
        found_o    = 1'b1;
        pick_ch_o  = CW'(c);
        pick_mst_o = f.mst[MW-1:0];
      end
    end
  end
endmodule

// File: rtl/arb_split_track.sv
module arb_split_track #(
  parameter int NM = 4,
  parameter int NS = 4,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arb_evt_i,
  input  logic          split_evt_i,
  input  logic [MW-1:0] cur_mst_i,
  input  logic [SW-1:0] cur_slv_i,
  input  logic [NM-1:0] release_i,
  output logic [NM-1:0] mask_now_o,
  output logic [NS-1:0] busy_now_o,
  output logic [NM-1:0] promo_o
);
  logic [NM-1:0] mask_q, promo_q, rel;
  logic [NS-1:0] busy_q;
  logic [MW-1:0] owner_q [NS];

  assign rel        = release_i & mask_q;
  assign mask_now_o = mask_q | (split_evt_i ? (NM'(1) << cur_mst_i) : '0);
  assign busy_now_o = busy_q | (split_evt_i ? (NS'(1) << cur_slv_i) : '0);
  assign promo_o    = promo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      promo_q <= '0;
      busy_q  <= '0;
      for (int s = 0; s < NS; s++) owner_q[s] <= '0;
    end else begin
      mask_q  <= (mask_q & ~rel) | (split_evt_i ? (NM'(1) << cur_mst_i) : '0);
      promo_q <= (arb_evt_i ? '0 : promo_q) | rel;
      for (int s = 0; s < NS; s++) begin
        if (split_evt_i && (32'(cur_slv_i) == s)) begin
          busy_q[s]  <= 1'b1;
          owner_q[s] <= cur_mst_i;
        end else if (busy_q[s] && rel[owner_q[s]]) begin
          busy_q[s]  <= 1'b0;
        end
      end
    end
  end

  AST_SPLIT_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_evt_i && !rel[cur_mst_i] |=> mask_q[$past(cur_mst_i)]); // R5

  AST_PROMO_ONE_ROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_evt_i && (rel == '0) |=> (promo_q == '0)); // R7

  for (genvar s = 0; s < NS; s++) begin : g_busy_chk
    AST_BUSY_OWNER_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q[s] |-> mask_q[owner_q[s]]); // R6
  end
endmodule

// File: rtl/arb_idle_watch.sv
module arb_idle_watch #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          parked_i,
  input  logic          bus_idle_i,
  input  logic [TW-1:0] limit_i,
  input  logic          clear_i,
  output logic          flag_o
);
  logic [TW-1:0] cnt_q;
  logic          flag_q, idle_now;

  assign idle_now = parked_i && bus_idle_i;
  assign flag_o   = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (clear_i || !idle_now) cnt_q <= '0;
      else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
      if (clear_i)                              flag_q <= 1'b0;
      else if (idle_now && (cnt_q == limit_i))  flag_q <= 1'b1;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clear_i |=> flag_q); // R9

  AST_FLAG_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(cnt_q) == $past(limit_i))); // R8
endmodule

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS  = 4,
  parameter int NUM_SLAVES   = 4,
  parameter int NUM_CFG_REGS = 2,
  parameter int TMO_W        = 16,
  localparam int NCH   = NUM_CFG_REGS * CH_PER_WORD,
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MST_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int SLV_W = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_MASTERS-1:0]       req_i,
  input  logic [NUM_MASTERS*SLV_W-1:0] req_slave_i,
  input  logic [NUM_CFG_REGS*32-1:0]   chan_cfg_i,
  input  logic                         ready_i,
  input  logic                         split_resp_i,
  input  logic                         bus_idle_i,
  input  logic [15:0]                  split_release_i,
  input  logic [TMO_W-1:0]             tmo_limit_i,
  input  logic                         tmo_to_reset_i,
  input  logic                         tmo_clear_i,
  output logic [NUM_MASTERS-1:0]       grant_o,
  output logic [MST_W-1:0]             master_o,
  output logic                         tmo_irq_o,
  output logic                         tmo_rst_o
);
  logic [MST_W-1:0]       cur_q, pick_mst, promo_mst;
  logic [CW-1:0]          last_q, pick_ch;
  logic [NCH*8-1:0]       chan_flat;
  logic [NUM_MASTERS-1:0] elig, mask_now, promo;
  logic [NUM_SLAVES-1:0]  busy_now;
  logic [SLV_W-1:0]       tgt [NUM_MASTERS];
  logic                   found, promo_hit, split_evt, tmo_flag;

  // Channel c lives in word c/4, highest byte first.
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam int OFS = CFG_WORD_W*(c/CH_PER_WORD) + 8*(CH_PER_WORD-1-(c%CH_PER_WORD));
    assign chan_flat[c*8 +: 8] = chan_cfg_i[OFS +: 8];
  end

  if (NUM_MASTERS < REL_W) begin : g_rel_unused
    logic unused_rel;
    assign unused_rel = ^split_release_i[REL_W-1:NUM_MASTERS];
  end

  assign split_evt = ready_i && split_resp_i;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_elig
    assign tgt[m]  = req_slave_i[m*SLV_W +: SLV_W];
    assign elig[m] = req_i[m] && !mask_now[m] && !busy_now[tgt[m]];
  end

  arb_split_track #(.NM(NUM_MASTERS), .NS(NUM_SLAVES)) u_split (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arb_evt_i   (ready_i),
    .split_evt_i (split_evt),
    .cur_mst_i   (cur_q),
    .cur_slv_i   (tgt[cur_q]),
    .release_i   (split_release_i[NUM_MASTERS-1:0]),
    .mask_now_o  (mask_now),
    .busy_now_o  (busy_now),
    .promo_o     (promo)
  );

  arb_chan_pick #(.NCH(NCH), .NM(NUM_MASTERS)) u_pick (
    .chan_flat_i (chan_flat),
    .elig_i      (elig),
    .last_ch_i   (last_q),
    .found_o     (found),
    .pick_ch_o   (pick_ch),
    .pick_mst_o  (pick_mst)
  );

  // Lowest freed master that is still eligible.
  always_comb begin
    promo_hit = 1'b0;
    promo_mst = '0;
    for (int m = NUM_MASTERS-1; m >= 0; m--) begin
      if (promo[m] && elig[m]) begin
        promo_hit = 1'b1;
        promo_mst = MST_W'(m);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      last_q <= CW'(NCH-1);
    end else if (ready_i) begin
      if (promo_hit) begin
        cur_q <= promo_mst;
      end else if (found) begin
        cur_q  <= pick_mst;
        last_q <= pick_ch;
      end else begin
        cur_q <= '0;
      end
    end
  end

  arb_idle_watch #(.TW(TMO_W)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .parked_i   (cur_q == '0),
    .bus_idle_i (bus_idle_i),
    .limit_i    (tmo_limit_i),
    .clear_i    (tmo_clear_i),
    .flag_o     (tmo_flag)
  );

  assign grant_o   = NUM_MASTERS'(1) << cur_q;
  assign master_o  = cur_q;
  assign tmo_irq_o = tmo_flag && !tmo_to_reset_i;
  assign tmo_rst_o = tmo_flag && tmo_to_reset_i;

  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(master_o)); // R4

  AST_TMO_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_irq_o |-> !tmo_rst_o && !tmo_to_reset_i); // R10
endmodule

// File: tb/split_bus_arbiter_tb.sv
module split_bus_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic [7:0]  req_slave = '0;
  logic [63:0] cfg = '0;
  logic        ready = 1'b0, split = 1'b0, idle = 1'b0;
  logic [15:0] rel = '0;
  logic [15:0] limit = 16'd5;
  logic        to_rst = 1'b0, clr = 1'b0;
  logic [3:0]  grant;
  logic [1:0]  mst;
  logic        irq, rstq;

  int checks = 0, errors = 0;
  int m_last, m_cur;

  always #10 clk = ~clk;

  split_bus_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_slave_i(req_slave),
    .chan_cfg_i(cfg), .ready_i(ready), .split_resp_i(split), .bus_idle_i(idle),
    .split_release_i(rel), .tmo_limit_i(limit), .tmo_to_reset_i(to_rst),
    .tmo_clear_i(clr), .grant_o(grant), .master_o(mst), .tmo_irq_o(irq),
    .tmo_rst_o(rstq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_grant(input string tag, input int exp);
    check({tag, " master"}, int'(mst), exp);
    check({tag, " onehot"}, int'(grant), 1 << exp);
  endtask

  task automatic step(input logic [3:0] r, input logic rdy, input logic spl, input logic [15:0] rl);
    req = r; ready = rdy; split = spl; rel = rl;
    @(posedge clk); #2;
    split = 1'b0; rel = '0; clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ready = 1'b0; req = '0; idle = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    m_last = 7; m_cur = 0;
  endtask

  // R2: channel byte position in the config vector
  function automatic logic [7:0] chan_byte(input int c);
    return cfg[32*(c/4) + 8*(3 - c%4) +: 8];
  endfunction

  // R3: round-robin expectation without any split state
  task automatic model_round(input logic [3:0] r);
    logic [7:0] f;
    int hit = -1;
    for (int i = 1; i <= 8; i++) begin
      int c = (m_last + i) % 8;
      f = chan_byte(c);
      if (hit < 0 && f[7] && f[3:0] < 4 && r[f[1:0]]) hit = c;
    end
    if (hit < 0) m_cur = 0;
    else begin m_cur = int'(chan_byte(hit) & 8'h0F); m_last = hit; end
  endtask

  task automatic sweep();
    for (int pass = 0; pass < 2; pass++) begin
      for (int r = 0; r < 16; r++) begin
        step(4'(15 - r), 1'b0, 1'b0, '0);
        check_grant("R4 hold while ready low", m_cur);
        step(4'(r), 1'b1, 1'b0, '0);
        model_round(4'(r));
        check_grant("R3 R2 round robin", m_cur);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfg = {32'h0, 32'h80818283};
    do_reset();
    check_grant("R1 reset park", 0);
    check("R1 irq low", int'(irq), 0);
    check("R1 rst low", int'(rstq), 0);

    sweep();
    // Mixed table: disabled channel, spare bits set, out-of-range master, duplicates
    cfg = {32'h81830080, 32'h8301B28F};
    do_reset();
    sweep();

    // Split handling: m0->s0, m1->s1, m2->s2, m3->s1
    cfg = {32'h0, 32'h80818283};
    req_slave = 8'b01_10_01_00;
    do_reset();
    step(4'b0110, 1'b1, 1'b0, '0);
    check_grant("R3 first winner", 1);
    step(4'b1110, 1'b1, 1'b1, '0);
    check_grant("R5 split moves grant", 2);
    step(4'b1110, 1'b1, 1'b0, '0);
    check_grant("R5 R6 masked and blocked skipped", 2);
    step(4'b1110, 1'b0, 1'b0, 16'h0002);
    check_grant("R4 release without ready", 2);
    step(4'b1110, 1'b1, 1'b0, '0);
    check_grant("R7 freed master wins", 1);
    step(4'b1110, 1'b1, 1'b0, '0);
    check_grant("R7 R6 single round then unblocked", 3);
    step(4'b0101, 1'b0, 1'b0, 16'h0004);
    step(4'b0101, 1'b1, 1'b0, '0);
    check_grant("R7 release of unmasked master ignored", 0);

    // Idle timeout on the default master
    req_slave = '0;
    do_reset();
    limit = 16'd5; to_rst = 1'b0; idle = 1'b1;
    for (int k = 1; k <= 5; k++) step(4'b0, 1'b1, 1'b0, '0);
    check("R8 no flag at limit cycles", int'(irq), 0);
    step(4'b0, 1'b1, 1'b0, '0);
    check("R8 flag after limit+1 cycles", int'(irq), 1);
    idle = 1'b0;
    step(4'b0, 1'b1, 1'b0, '0);
    step(4'b0, 1'b1, 1'b0, '0);
    check("R9 flag sticky", int'(irq), 1);
    clr = 1'b1;
    step(4'b0, 1'b1, 1'b0, '0);
    check("R9 clear drops flag", int'(irq), 0);
    to_rst = 1'b1; idle = 1'b1;
    for (int k = 1; k <= 6; k++) step(4'b0, 1'b1, 1'b0, '0);
    check("R10 reset request", int'(rstq), 1);
    check("R10 irq quiet", int'(irq), 0);
    clr = 1'b1;
    step(4'b0, 1'b1, 1'b0, '0);
    check("R9 clear reset request", int'(rstq), 0);
    for (int k = 1; k <= 4; k++) step(4'b0, 1'b1, 1'b0, '0);
    idle = 1'b0;
    step(4'b0, 1'b1, 1'b0, '0);
    idle = 1'b1;
    for (int k = 1; k <= 5; k++) step(4'b0, 1'b1, 1'b0, '0);
    check("R8 busy cycle restarts count", int'(rstq), 0);
    step(4'b0, 1'b1, 1'b0, '0);
    check("R8 flag after restart", int'(rstq), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule